// File: doc/BRIEF.md
# Completion Buffer Pre-Allocation Tracker

This block sits between an internal read requester and the receive side of a serial link whose completion credits are advertised as unlimited to the link partner. The partner never waits for completion credit, so every completion it returns must fit in local storage. The tracker enforces this by reserving buffer space before a read request goes out. A read request is held back while the bytes already reserved plus the new read's length would go past the 4096-byte completion store. It is also held back while all four completion header slots are taken.

Each reservation is kept per tag. Completions arrive as bursts of 32-bit beats and are taken in every cycle, with no ready signal. Data is written to a 1024-beat store. When the last beat of a burst arrives, one header (tag and beat count) is written to a four-entry header queue. A burst is offered on the egress port only after it has been stored in full. Reserved space is returned as the egress port delivers the data: four bytes per beat, and whatever remains of the tag's reservation on the final beat, along with its header slot.

Top module: `cpl_prealloc_tracker`

## Requirements
- R1: After reset, out_valid is 0, and a request of any length from 4 to 4096 bytes on any tag shows req_ready 1.
- R2: req_ready is 0 while the bytes reserved plus req_len would exceed 4096, and it is also 0 for req_len 0. A request that brings the total to exactly 4096 is accepted.
- R3: req_ready is 0 while 4 reservations are outstanding, whatever the length.
- R4: req_ready is 0 for a tag that already holds a reservation.
- R5: Completion beats are taken in every cycle where cpl_valid is 1, with no backpressure. They must carry a reserved tag. A burst ends on the beat with cpl_last 1.
- R6: out_valid rises in the cycle after the last beat of a burst is taken. Bursts leave in arrival order with data unchanged, out_tag equal to the burst tag, and out_last 1 on the final beat only.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_tag and out_last hold.
- R8: Each delivered beat frees 4 reserved bytes. The final beat of a burst also frees the rest of that tag's reservation and its header slot, even when the burst is shorter than reserved. Once everything has drained, a 4096-byte request is accepted.
- R9: In the same cycle, a completion beat can be stored while an egress beat is delivered. Space freed at a clock edge appears in req_ready from the next cycle. A request in the freeing cycle is judged against the old totals.
- R10: cpl_credit_unlimited is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request presented |
| req_ready | output | 1 | Request may issue; depends on req_tag, req_len and the state, not on req_valid |
| req_tag | input | 5 | Tag of the read request |
| req_len | input | 13 | Bytes requested, a multiple of 4 |
| cpl_valid | input | 1 | Completion beat present; always taken |
| cpl_tag | input | 5 | Tag of the completion, constant within a burst |
| cpl_data | input | 32 | Completion data beat |
| cpl_last | input | 1 | Final beat of the burst |
| out_valid | output | 1 | Egress beat available |
| out_ready | input | 1 | Requester takes the egress beat |
| out_tag | output | 5 | Tag of the burst being delivered |
| out_data | output | 32 | Egress data beat |
| out_last | output | 1 | Final beat of the burst |
| cpl_credit_unlimited | output | 1 | Unlimited completion credits advertised |

## Verification
Two pairs of events can land in the same cycle. The first pair is a completion beat being stored while an egress beat is delivered. The second is a request being judged while the final egress beat of a burst frees a header slot. The bench fills all four header slots and stores one burst. It then streams the next burst in while draining the first, and in the freeing cycle it probes with a fresh tag. That probe must see req_ready 0 in the freeing cycle and 1 in the cycle after, and both bursts must come out intact and in order.

// File: rtl/cplres_pkg.sv
package cplres_pkg;

    localparam int BUF_BYTES  = 4096;
    localparam int HDR_SLOTS  = 4;
    localparam int TAG_W      = 5;
    localparam int DATA_W     = 32;

    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int NUM_TAGS   = 1 << TAG_W;
    localparam int BUF_BEATS  = BUF_BYTES / BEAT_BYTES;
    localparam int LEN_W      = $clog2(BUF_BYTES) + 1;
    localparam int BEATS_W    = $clog2(BUF_BEATS) + 1;
    localparam int HC_W       = $clog2(HDR_SLOTS + 1);

    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [LEN_W-1:0]   len_t;
    typedef logic [BEATS_W-1:0] beats_t;
    typedef logic [HC_W-1:0]    hcnt_t;
    typedef logic [DATA_W-1:0]  data_t;

    localparam len_t  BUF_LEN  = len_t'(BUF_BYTES);
    localparam len_t  BEAT_LEN = len_t'(BEAT_BYTES);
    localparam hcnt_t HDR_FULL = hcnt_t'(HDR_SLOTS);

    typedef struct packed {
        tag_t   tag;
        beats_t beats;
    } cpl_hdr_t;

    // True when adding len to the current reservation stays within the store.
    function automatic logic fits_store(len_t resv, len_t len);
        logic [LEN_W:0] total;
        total = {1'b0, resv} + {1'b0, len};
        return (total <= {1'b0, BUF_LEN});
    endfunction

    // Bytes returned by one delivered beat of a tag with rem bytes still held.
    function automatic len_t beat_release(len_t rem, logic final_beat);
        if (final_beat)
            return rem;
        return (rem < BEAT_LEN) ? rem : BEAT_LEN;
    endfunction

endpackage

// File: rtl/cplres_fifo.sv
module cplres_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;

    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push)
                wr_ptr <= bump(wr_ptr);
            if (pop)
                rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (cnt_q == '0);
    assign count = cnt_q;

endmodule

// File: rtl/cplres_ledger.sv
module cplres_ledger
    import cplres_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  tag_t                req_tag,
    input  len_t                req_len,
    output logic                req_ready,
    input  logic                rel_valid,
    input  tag_t                rel_tag,
    input  logic                rel_last,
    output len_t                resv_bytes,
    output hcnt_t               hdr_used,
    output logic [NUM_TAGS-1:0] tag_busy
);

    logic [NUM_TAGS-1:0] busy_q;
    len_t                rem_q [NUM_TAGS];
    len_t                resv_q;
    hcnt_t               hdr_q;

    logic                issue;
    logic [NUM_TAGS-1:0] iss_hit;
    logic [NUM_TAGS-1:0] rel_hit;
    len_t                rel_rem;
    len_t                rel_amt;
    len_t                rel_step;

    // Admission uses registered totals only; same-cycle releases are not credited.
    assign req_ready = !busy_q[req_tag]
                     && (hdr_q < HDR_FULL)
                     && (req_len != '0)
                     && fits_store(resv_q, req_len);

    assign issue    = req_valid && req_ready;
    assign rel_rem  = rem_q[rel_tag];
    assign rel_amt  = beat_release(rel_rem, rel_last);
    assign rel_step = beat_release(rel_rem, 1'b0);

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_tag
        assign iss_hit[g] = issue && (req_tag == tag_t'(g));
        assign rel_hit[g] = rel_valid && (rel_tag == tag_t'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            for (int t = 0; t < NUM_TAGS; t++)
                rem_q[t] <= '0;
        end else begin
            for (int t = 0; t < NUM_TAGS; t++) begin
                if (iss_hit[t]) begin
                    busy_q[t] <= 1'b1;
                    rem_q[t]  <= req_len;
                end else if (rel_hit[t]) begin
                    if (rel_last) begin
                        busy_q[t] <= 1'b0;
                        rem_q[t]  <= '0;
                    end else begin
                        rem_q[t]  <= rem_q[t] - rel_step;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resv_q <= '0;
            hdr_q  <= '0;
        end else begin
            resv_q <= resv_q
                    + (issue ? req_len : '0)
                    - (rel_valid ? rel_amt : '0);
            hdr_q  <= hdr_q
                    + (issue ? hcnt_t'(1) : '0)
                    - ((rel_valid && rel_last) ? hcnt_t'(1) : '0);
        end
    end

    assign resv_bytes = resv_q;
    assign hdr_used   = hdr_q;
    assign tag_busy   = busy_q;

endmodule

// File: rtl/cplres_egress.sv
module cplres_egress
    import cplres_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hdr_empty,
    input  cpl_hdr_t hdr_head,
    input  data_t    data_head,
    input  logic     out_ready,
    output logic     out_valid,
    output tag_t     out_tag,
    output data_t    out_data,
    output logic     out_last,
    output logic     data_pop,
    output logic     hdr_pop
);

    beats_t beat_q;
    logic   fire;

    assign out_valid = !hdr_empty;
    assign out_tag   = hdr_head.tag;
    assign out_data  = data_head;
    assign out_last  = (beat_q == hdr_head.beats - beats_t'(1));
    assign fire      = out_valid && out_ready;
    assign data_pop  = fire;
    assign hdr_pop   = fire && out_last;

    always_ff @(posedge clk) begin
        if (rst)
            beat_q <= '0;
        else if (fire)
            beat_q <= out_last ? '0 : beat_q + beats_t'(1);
    end

endmodule

// File: rtl/cpl_prealloc_tracker.sv
module cpl_prealloc_tracker
    import cplres_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [TAG_W-1:0]    req_tag,
    input  logic [LEN_W-1:0]    req_len,
    input  logic                cpl_valid,
    input  logic [TAG_W-1:0]    cpl_tag,
    input  logic [DATA_W-1:0]   cpl_data,
    input  logic                cpl_last,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [TAG_W-1:0]    out_tag,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_last,
    output logic                cpl_credit_unlimited
);

    localparam int HDR_CW  = $clog2(HDR_SLOTS + 1);
    localparam int DATA_CW = $clog2(BUF_BEATS + 1);

    len_t                resv_bytes;
    hcnt_t               hdr_used;
    logic [NUM_TAGS-1:0] tag_busy;

    beats_t              in_beats_q;
    cpl_hdr_t            hdr_in;
    cpl_hdr_t            hdr_head;
    logic                hdr_push, hdr_pop, hdr_empty;
    logic [HDR_CW-1:0]   hdr_stored;

    data_t               data_head;
    logic                data_pop, data_empty;
    logic [DATA_CW-1:0]  data_cnt;

    assign cpl_credit_unlimited = 1'b1;

    // Ingress: count beats of the running burst; header written on its last beat.
    always_ff @(posedge clk) begin
        if (rst)
            in_beats_q <= '0;
        else if (cpl_valid)
            in_beats_q <= cpl_last ? '0 : in_beats_q + beats_t'(1);
    end

    assign hdr_push     = cpl_valid && cpl_last;
    assign hdr_in.tag   = cpl_tag;
    assign hdr_in.beats = in_beats_q + beats_t'(1);

    cplres_ledger i_ledger (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_tag    (req_tag),
        .req_len    (req_len),
        .req_ready  (req_ready),
        .rel_valid  (data_pop),
        .rel_tag    (out_tag),
        .rel_last   (out_last),
        .resv_bytes (resv_bytes),
        .hdr_used   (hdr_used),
        .tag_busy   (tag_busy)
    );

    cplres_fifo #(
        .W     (DATA_W),
        .DEPTH (BUF_BEATS)
    ) i_data_q (
        .clk   (clk),
        .rst   (rst),
        .push  (cpl_valid),
        .din   (cpl_data),
        .pop   (data_pop),
        .dout  (data_head),
        .empty (data_empty),
        .count (data_cnt)
    );

    cplres_fifo #(
        .W     ($bits(cpl_hdr_t)),
        .DEPTH (HDR_SLOTS)
    ) i_hdr_q (
        .clk   (clk),
        .rst   (rst),
        .push  (hdr_push),
        .din   (hdr_in),
        .pop   (hdr_pop),
        .dout  (hdr_head),
        .empty (hdr_empty),
        .count (hdr_stored)
    );

    cplres_egress i_egress (
        .clk       (clk),
        .rst       (rst),
        .hdr_empty (hdr_empty),
        .hdr_head  (hdr_head),
        .data_head (data_head),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_tag   (out_tag),
        .out_data  (out_data),
        .out_last  (out_last),
        .data_pop  (data_pop),
        .hdr_pop   (hdr_pop)
    );

endmodule

// File: rtl/cplres_chk.sv
module cplres_chk
    import cplres_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic [TAG_W-1:0]    req_tag,
    input logic                cpl_valid,
    input logic [TAG_W-1:0]    cpl_tag,
    input logic                out_valid,
    input logic                out_ready,
    input logic [TAG_W-1:0]    out_tag,
    input logic [DATA_W-1:0]   out_data,
    input logic                out_last,
    input len_t                resv_bytes,
    input hcnt_t               hdr_used,
    input logic [NUM_TAGS-1:0] tag_busy,
    input logic [$clog2(BUF_BEATS+1)-1:0] data_cnt,
    input logic                data_empty,
    input logic [$clog2(HDR_SLOTS+1)-1:0] hdr_stored
);

    // R2
    resv_bound_chk: assert property (@(posedge clk) disable iff (rst)
        resv_bytes <= BUF_LEN);

    // R2
    stored_within_resv_chk: assert property (@(posedge clk) disable iff (rst)
        ((LEN_W+2)'(data_cnt) * (LEN_W+2)'(BEAT_BYTES)) <= (LEN_W+2)'(resv_bytes));

    // R3
    hdr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (hdr_used <= HDR_FULL) && (HC_W'(hdr_stored) <= hdr_used));

    // R3
    hdr_full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hdr_used == HDR_FULL) |-> !req_ready);

    // R4
    dup_tag_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && tag_busy[req_tag]) |-> !req_ready);

    // R5
    cpl_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> tag_busy[cpl_tag]);

    // R6
    egress_has_data_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !data_empty);

    // R7
    egress_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_tag) && $stable(out_last)));

    // R8
    release_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !tag_busy[$past(out_tag)]);

endmodule

bind cpl_prealloc_tracker cplres_chk i_cplres_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_tag    (req_tag),
    .cpl_valid  (cpl_valid),
    .cpl_tag    (cpl_tag),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_tag    (out_tag),
    .out_data   (out_data),
    .out_last   (out_last),
    .resv_bytes (resv_bytes),
    .hdr_used   (hdr_used),
    .tag_busy   (tag_busy),
    .data_cnt   (data_cnt),
    .data_empty (data_empty),
    .hdr_stored (hdr_stored)
);

// File: tb/test_cpl_prealloc_tracker.sv
module test_cpl_prealloc_tracker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_tag = '0;
    logic [12:0] req_len = '0;
    logic        cpl_valid = 1'b0;
    logic [4:0]  cpl_tag = '0;
    logic [31:0] cpl_data = '0;
    logic        cpl_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [4:0]  out_tag;
    logic [31:0] out_data;
    logic        out_last;
    logic        cpl_credit_unlimited;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    cpl_prealloc_tracker i_cpl_prealloc_tracker (
        .clk                  (clk),
        .rst                  (rst),
        .req_valid            (req_valid),
        .req_ready            (req_ready),
        .req_tag              (req_tag),
        .req_len              (req_len),
        .cpl_valid            (cpl_valid),
        .cpl_tag              (cpl_tag),
        .cpl_data             (cpl_data),
        .cpl_last             (cpl_last),
        .out_valid            (out_valid),
        .out_ready            (out_ready),
        .out_tag              (out_tag),
        .out_data             (out_data),
        .out_last             (out_last),
        .cpl_credit_unlimited (cpl_credit_unlimited)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present a request at a falling edge; commit decides whether req_valid is raised.
    task automatic try_req(input logic [4:0] tag, input logic [12:0] len,
                           input logic exp, input logic commit, input string req);
        req_tag   = tag;
        req_len   = len;
        req_valid = commit;
        #1;
        check(req, "req_ready", req_ready, exp);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_cpl(input logic [4:0] tag, input int n, input logic [31:0] base,
                            input logic expect_idle);
        for (int i = 0; i < n; i++) begin
            cpl_valid = 1'b1;
            cpl_tag   = tag;
            cpl_data  = base + 32'(i);
            cpl_last  = (i == n - 1);
            #1;
            if (expect_idle)
                check("R6", "out_valid before burst end", out_valid, 1'b0);
            @(posedge clk);
            @(negedge clk);
        end
        cpl_valid = 1'b0;
        cpl_last  = 1'b0;
    endtask

    task automatic drain(input logic [4:0] tag, input int n, input logic [31:0] base);
        out_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            #1;
            check("R6", "out_valid", out_valid, 1'b1);
            check("R6", "out_tag",   out_tag,   tag);
            check("R6", "out_data",  out_data,  base + 32'(i));
            check("R6", "out_last",  out_last,  (i == n - 1));
            @(posedge clk);
            @(negedge clk);
        end
        out_ready = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check("R1", "out_valid after reset", out_valid, 1'b0);
        check("R10", "credit flag", cpl_credit_unlimited, 1'b1);
        try_req(5'd0, 13'd4096, 1'b1, 1'b0, "R1");
        try_req(5'd31, 13'd4, 1'b1, 1'b0, "R1");
    endtask

    task automatic t_basic;
        try_req(5'd1, 13'd16, 1'b1, 1'b1, "R1");
        send_cpl(5'd1, 4, 32'hA100_0000, 1'b1);
        drain(5'd1, 4, 32'hA100_0000);
        #1;
        check("R6", "out_valid after drain", out_valid, 1'b0);
    endtask

    task automatic t_byte_limit;
        try_req(5'd0, 13'd0, 1'b0, 1'b0, "R2");
        try_req(5'd2, 13'd4000, 1'b1, 1'b1, "R2");
        try_req(5'd3, 13'd100, 1'b0, 1'b1, "R2");
        try_req(5'd3, 13'd96, 1'b1, 1'b1, "R2");
        try_req(5'd4, 13'd4, 1'b0, 1'b0, "R2");
        send_cpl(5'd2, 1000, 32'hB200_0000, 1'b1);
        send_cpl(5'd3, 24, 32'hB300_0000, 1'b0);
        drain(5'd2, 1000, 32'hB200_0000);
        try_req(5'd4, 13'd4000, 1'b1, 1'b0, "R8");
        drain(5'd3, 24, 32'hB300_0000);
        try_req(5'd4, 13'd4096, 1'b1, 1'b0, "R8");
    endtask

    task automatic t_hdr_and_hold;
        try_req(5'd6, 13'd16, 1'b1, 1'b1, "R3");
        try_req(5'd6, 13'd4, 1'b0, 1'b1, "R4");
        try_req(5'd7, 13'd16, 1'b1, 1'b1, "R3");
        try_req(5'd8, 13'd16, 1'b1, 1'b1, "R3");
        try_req(5'd9, 13'd16, 1'b1, 1'b1, "R3");
        try_req(5'd10, 13'd4, 1'b0, 1'b1, "R3");
        send_cpl(5'd6, 4, 32'hC600_0000, 1'b1);
        #1;
        check("R7", "out_valid held", out_valid, 1'b1);
        check("R7", "out_data held", out_data, 32'hC600_0000);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            #1;
            check("R7", "out_valid held", out_valid, 1'b1);
            check("R7", "out_data held", out_data, 32'hC600_0000);
            check("R7", "out_last held", out_last, 1'b0);
        end
        drain(5'd6, 4, 32'hC600_0000);
        try_req(5'd11, 13'd8, 1'b1, 1'b1, "R3");
    endtask

    task automatic t_overlap;
        send_cpl(5'd7, 4, 32'hD700_0000, 1'b1);
        out_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            cpl_valid = 1'b1;
            cpl_tag   = 5'd8;
            cpl_data  = 32'hD800_0000 + 32'(i);
            cpl_last  = (i == 3);
            req_tag   = 5'd12;
            req_len   = 13'd4;
            #1;
            check("R9", "out_data during ingress", out_data, 32'hD700_0000 + 32'(i));
            check("R9", "out_tag during ingress", out_tag, 5'd7);
            check("R9", "out_last during ingress", out_last, (i == 3));
            if (i == 3)
                check("R9", "req_ready in freeing cycle", req_ready, 1'b0);
            @(posedge clk);
            @(negedge clk);
        end
        cpl_valid = 1'b0;
        cpl_last  = 1'b0;
        #1;
        check("R9", "req_ready after freeing edge", req_ready, 1'b1);
        drain(5'd8, 4, 32'hD800_0000);
        send_cpl(5'd9, 4, 32'hD900_0000, 1'b1);
        send_cpl(5'd11, 1, 32'hDB00_0000, 1'b0);
        drain(5'd9, 4, 32'hD900_0000);
        drain(5'd11, 1, 32'hDB00_0000);
        #1;
        check("R8", "out_valid after all drained", out_valid, 1'b0);
        try_req(5'd11, 13'd4096, 1'b1, 1'b0, "R8");
        try_req(5'd20, 13'd4096, 1'b1, 1'b0, "R8");
        check("R10", "credit flag", cpl_credit_unlimited, 1'b1);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_byte_limit();
        t_hdr_and_hold();
        t_overlap();
        finish_run();
    end

endmodule